// File: doc/BRIEF.md
# Overload Duty and Frequency Foldback Controller

This block sits between the voltage regulation loop of a fixed-frequency PWM converter and its PWM timebase. Once per switching period it issues an on-time and a period length, both counted in timebase ticks. While the primary current stays below the limit, the on-time follows the voltage-loop command, which is capped at the maximum duty. The period stays at its nominal length.

Two comparator flags report overload. One says the sensed current is above the lower trigger and the other says it is above the upper trigger. A digital limit level stands in for the external timing capacitor. Each clock tick that the lower flag is high during a period lowers this level. Any assertion of the upper flag collapses it to zero. A falling level first trims the on-time down to a floor of one eighth of the nominal period. Below that point the on-time stays at the floor and the period lengthens one tick for each unit of level, out to five times nominal. At that point the effective duty is one fortieth.

In any period that ends without the lower flag, the outputs return at once to voltage-loop control with no soft-start ramp. The limit level climbs back towards its idle value by a fixed step per clean period.

Top module: `ovl_foldback_ctrl`

## Requirements
- R1: After reset the on-time output is 0, the period output equals P_NOM (40), `limit_active` is 0, and the limit level sits at its idle value LVL_MAX = 192.
- R2: When a period ends with no lower-flag tick, the new outputs are on-time = min(command, D_MAX = 37), period = P_NOM = 40, and `limit_active` = 0.
- R3: Each clock tick of a period in which `over_lo` is 1 (the ending tick included) lowers the limit level by DEC_GAIN (1). While the level L is at least KNEE = 160, the outputs are on-time = min(command, 37, 5 + L − 160) and period = 40, with `limit_active` = 1.
- R4: While limited with L < 160, the on-time is min(command, T_FLOOR = 5) and the period is 40 + 160 − L. The period always stays within [40, 200].
- R5: If `over_hi` is 1 on any tick of a period, the level becomes 0 at that period's end. The outputs then become period 200 and on-time min(command, 5). The upper flag is only ever raised together with `over_lo`.
- R6: The limit level never goes below 0 or above 192. A decrement larger than the level leaves it at 0.
- R7: Each clean period raises the level by REC_STEP = 4, up to a cap of 192. The outputs return to the full R2 values on the first clean period, with no gradual ramp.
- R8: The command and the outputs change only at the tick where `period_end` is 1. A change to `vloop_on` on any other tick has no effect on the outputs.
- R9: The on-time never exceeds the period. While limited with a command of at least 5, the on-time is at least 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_end | input | 1 | Last tick of the current switching period, driven by the timebase |
| over_lo | input | 1 | Sensed current is above the lower trigger |
| over_hi | input | 1 | Sensed current is above the upper trigger |
| vloop_on | input | 16 | On-time requested by the voltage loop, in ticks |
| on_ticks | output | 16 | Effective on-time for the next period |
| per_ticks | output | 16 | Switching period length for the next period |
| limit_active | output | 1 | 1 while the current-limit loop governs the command |

## Verification
The assertions assume that `over_hi` is never high unless `over_lo` is also high, because a current above the upper trigger is also above the lower one. The stimulus raises the upper flag only on a tick where it also holds the lower flag.

The assertions also assume that `period_end` marks whole periods. The bench drives every period as a fixed number of ticks with a single end strobe. It places lower-flag ticks at the start of the period. It changes `vloop_on` only in the middle of a period when it is probing R8, and it restores the intended value on the closing tick.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int unsigned TICK_W = 16;

    typedef logic [TICK_W-1:0] tick_t;

    typedef enum logic {
        MODE_VOLT  = 1'b0,
        MODE_LIMIT = 1'b1
    } ctl_mode_t;

    typedef struct packed {
        tick_t on_ticks;
        tick_t per_ticks;
    } pwm_cmd_t;

    function automatic tick_t tick_min(tick_t a, tick_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic tick_t tick_sat_inc(tick_t a);
        return (a == '1) ? a : a + tick_t'(1);
    endfunction

endpackage

// File: rtl/ovl_excess_acc.sv
module ovl_excess_acc
    import ovl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  period_end,
    input  logic  over_lo,
    input  logic  over_hi,
    output tick_t excess_cnt,
    output logic  collapse
);

    tick_t acc_q;
    logic  hi_q;

    // Totals include the current tick so the ending tick also counts.
    always_comb begin
        excess_cnt = over_lo ? tick_sat_inc(acc_q) : acc_q;
        collapse   = hi_q | over_hi;
    end

    always_ff @(posedge clk) begin
        if (rst || period_end) begin
            acc_q <= '0;
            hi_q  <= 1'b0;
        end else begin
            acc_q <= excess_cnt;
            hi_q  <= collapse;
        end
    end

    AST_HI_IMPLIES_LO: assert property (@(posedge clk) disable iff (rst)
        over_hi |-> over_lo);  // R5

endmodule

// File: rtl/ovl_limit_integ.sv
module ovl_limit_integ
    import ovl_pkg::*;
#(
    parameter int unsigned LVL_MAX  = 192,
    parameter int unsigned REC_STEP = 4,
    parameter int unsigned DEC_GAIN = 1,
    parameter int unsigned LVL_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             period_end,
    input  tick_t            excess_cnt,
    input  logic             collapse,
    output logic [LVL_W-1:0] lvl,
    output ctl_mode_t        mode
);

    logic [LVL_W-1:0] lvl_q, lvl_d;
    ctl_mode_t        mode_q, mode_d;
    logic [31:0]      dec_amt, lvl_ext, up_amt;

    always_comb begin
        lvl_ext = 32'(lvl_q);
        dec_amt = 32'(excess_cnt) * DEC_GAIN;
        up_amt  = lvl_ext + REC_STEP;
        if (collapse) begin
            lvl_d  = '0;
            mode_d = MODE_LIMIT;
        end else if (excess_cnt != '0) begin
            lvl_d  = (lvl_ext > dec_amt) ? LVL_W'(lvl_ext - dec_amt) : '0;
            mode_d = MODE_LIMIT;
        end else begin
            lvl_d  = (up_amt > LVL_MAX) ? LVL_W'(LVL_MAX) : LVL_W'(up_amt);
            mode_d = MODE_VOLT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= LVL_W'(LVL_MAX);
            mode_q <= MODE_VOLT;
        end else if (period_end) begin
            lvl_q  <= lvl_d;
            mode_q <= mode_d;
        end
    end

    assign lvl  = lvl_q;
    assign mode = mode_q;

    AST_COLLAPSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        period_end && collapse |=> lvl_q == '0 && mode_q == MODE_LIMIT);  // R5
    AST_DECAY: assert property (@(posedge clk) disable iff (rst)
        period_end && !collapse && excess_cnt != '0 |=> (lvl_q < $past(lvl_q)) || (lvl_q == '0));  // R3
    AST_RECOVER_UP: assert property (@(posedge clk) disable iff (rst)
        period_end && !collapse && excess_cnt == '0 |=> lvl_q >= $past(lvl_q) && mode_q == MODE_VOLT);  // R7
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(lvl_q) && $stable(mode_q));  // R8
    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
        32'(lvl_q) <= LVL_MAX);  // R6

endmodule

// File: rtl/ovl_cmd_map.sv
module ovl_cmd_map
    import ovl_pkg::*;
#(
    parameter int unsigned P_NOM   = 40,
    parameter int unsigned T_FLOOR = 5,
    parameter int unsigned KNEE    = 160,
    parameter int unsigned D_MAX   = 37,
    parameter int unsigned LVL_W   = 8
) (
    input  logic [LVL_W-1:0] lvl,
    input  ctl_mode_t        mode,
    input  tick_t            vcmd,
    output pwm_cmd_t         cmd
);

    tick_t       vcl;
    logic [31:0] lvl_ext;

    always_comb begin
        lvl_ext = 32'(lvl);
        vcl     = tick_min(vcmd, tick_t'(D_MAX));
        if (mode == MODE_VOLT) begin
            cmd.on_ticks  = vcl;
            cmd.per_ticks = tick_t'(P_NOM);
        end else if (lvl_ext >= KNEE) begin
            // Duty region: trim on-time, keep nominal frequency.
            cmd.on_ticks  = tick_min(vcl, tick_t'(T_FLOOR + lvl_ext - KNEE));
            cmd.per_ticks = tick_t'(P_NOM);
        end else begin
            // Fold region: hold the on-time floor, stretch the period.
            cmd.on_ticks  = tick_min(vcl, tick_t'(T_FLOOR));
            cmd.per_ticks = tick_t'(P_NOM + KNEE - lvl_ext);
        end
    end

endmodule

// File: rtl/ovl_foldback_ctrl.sv
module ovl_foldback_ctrl
    import ovl_pkg::*;
#(
    parameter int unsigned P_NOM     = 40,
    parameter int unsigned FLOOR_DIV = 8,
    parameter int unsigned FOLD_MULT = 5,
    parameter int unsigned D_MAX     = 37,
    parameter int unsigned REC_STEP  = 4,
    parameter int unsigned DEC_GAIN  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        period_end,
    input  logic        over_lo,
    input  logic        over_hi,
    input  logic [15:0] vloop_on,
    output logic [15:0] on_ticks,
    output logic [15:0] per_ticks,
    output logic        limit_active
);

    localparam int unsigned T_FLOOR = P_NOM / FLOOR_DIV;
    localparam int unsigned P_MAX   = P_NOM * FOLD_MULT;
    localparam int unsigned KNEE    = P_MAX - P_NOM;
    localparam int unsigned LVL_MAX = KNEE + D_MAX - T_FLOOR;
    localparam int unsigned LVL_W   = $clog2(LVL_MAX + 1);

    tick_t            excess_cnt;
    logic             collapse;
    logic [LVL_W-1:0] lvl;
    ctl_mode_t        mode;
    tick_t            vcmd_q;
    pwm_cmd_t         cmd;

    always_ff @(posedge clk) begin
        if (rst)             vcmd_q <= '0;
        else if (period_end) vcmd_q <= tick_t'(vloop_on);
    end

    ovl_excess_acc i_acc (
        .clk        (clk),
        .rst        (rst),
        .period_end (period_end),
        .over_lo    (over_lo),
        .over_hi    (over_hi),
        .excess_cnt (excess_cnt),
        .collapse   (collapse)
    );

    ovl_limit_integ #(
        .LVL_MAX  (LVL_MAX),
        .REC_STEP (REC_STEP),
        .DEC_GAIN (DEC_GAIN),
        .LVL_W    (LVL_W)
    ) i_integ (
        .clk        (clk),
        .rst        (rst),
        .period_end (period_end),
        .excess_cnt (excess_cnt),
        .collapse   (collapse),
        .lvl        (lvl),
        .mode       (mode)
    );

    ovl_cmd_map #(
        .P_NOM   (P_NOM),
        .T_FLOOR (T_FLOOR),
        .KNEE    (KNEE),
        .D_MAX   (D_MAX),
        .LVL_W   (LVL_W)
    ) i_map (
        .lvl  (lvl),
        .mode (mode),
        .vcmd (vcmd_q),
        .cmd  (cmd)
    );

    assign on_ticks     = cmd.on_ticks;
    assign per_ticks    = cmd.per_ticks;
    assign limit_active = (mode == MODE_LIMIT);

    AST_ON_WITHIN_PER: assert property (@(posedge clk) disable iff (rst)
        on_ticks <= per_ticks);  // R9
    AST_PER_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        32'(per_ticks) >= P_NOM && 32'(per_ticks) <= P_MAX);  // R4
    AST_VOLT_NOMINAL: assert property (@(posedge clk) disable iff (rst)
        !limit_active |-> 32'(per_ticks) == P_NOM);  // R2
    AST_ONTIME_FLOOR: assert property (@(posedge clk) disable iff (rst)
        limit_active && 32'(vcmd_q) >= T_FLOOR |-> 32'(on_ticks) >= T_FLOOR);  // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(on_ticks) && $stable(per_ticks));  // R8

endmodule

// File: tb/test_ovl_foldback_ctrl.sv
module test_ovl_foldback_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LEN        = 42;
    localparam int P_NOM      = 40;
    localparam int T_FLOOR    = 5;
    localparam int P_MAX      = 200;
    localparam int KNEE       = 160;
    localparam int D_MAX      = 37;
    localparam int LVL_MAX    = 192;
    localparam int REC        = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        period_end;
    logic        over_lo;
    logic        over_hi;
    logic [15:0] vloop_on;
    logic [15:0] on_ticks;
    logic [15:0] per_ticks;
    logic        limit_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_foldback_ctrl i_ovl_foldback_ctrl (
        .clk          (clk),
        .rst          (rst),
        .period_end   (period_end),
        .over_lo      (over_lo),
        .over_hi      (over_hi),
        .vloop_on     (vloop_on),
        .on_ticks     (on_ticks),
        .per_ticks    (per_ticks),
        .limit_active (limit_active)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int m_lvl;
    bit m_lim;
    int exp_on;
    int exp_per;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model(int cnt, bit hi, int vc);
        int vcl;
        if (hi) begin
            m_lvl = 0; m_lim = 1;
        end else if (cnt > 0) begin
            m_lvl = (m_lvl > cnt) ? m_lvl - cnt : 0; m_lim = 1;
        end else begin
            m_lvl = imin(m_lvl + REC, LVL_MAX); m_lim = 0;
        end
        vcl = imin(vc, D_MAX);
        if (!m_lim) begin
            exp_on = vcl; exp_per = P_NOM;
        end else if (m_lvl >= KNEE) begin
            exp_on = imin(vcl, T_FLOOR + m_lvl - KNEE); exp_per = P_NOM;
        end else begin
            exp_on = imin(vcl, T_FLOOR); exp_per = P_NOM + KNEE - m_lvl;
        end
    endtask

    // noise >= 0: vloop_on carries that value mid-period (R8 probe)
    task automatic run_period(int lo_n, bit hi, int vc, int noise, string req);
        for (int t = 0; t < LEN; t++) begin
            @(negedge clk);
            over_lo    = (t < lo_n);
            over_hi    = hi && (t == 0);
            vloop_on   = (t == LEN-1 || noise < 0) ? 16'(vc) : 16'(noise);
            period_end = (t == LEN-1);
            if (noise >= 0 && t == LEN/2) begin
                chk("R8", "on mid-period", int'(on_ticks), exp_on);
                chk("R8", "per mid-period", int'(per_ticks), exp_per);
            end
        end
        model(lo_n, hi, vc);
        @(negedge clk);
        period_end = 1'b0; over_lo = 1'b0; over_hi = 1'b0;
        chk(req, "on", int'(on_ticks), exp_on);
        chk(req, "per", int'(per_ticks), exp_per);
        chk(req, "limit", int'(limit_active), int'(m_lim));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1-run: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int vlist[9];
        vlist = '{0, 1, 5, 20, 36, 37, 38, 100, 65535};
        rst = 1'b1; period_end = 1'b0; over_lo = 1'b0; over_hi = 1'b0; vloop_on = 16'd0;
        m_lvl = LVL_MAX; m_lim = 0; exp_on = 0; exp_per = P_NOM;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "on", int'(on_ticks), 0);
        chk("R1", "per", int'(per_ticks), P_NOM);
        chk("R1", "limit", int'(limit_active), 0);

        // R2 and R8: voltage mode across commands, with mid-period noise
        foreach (vlist[i]) run_period(0, 1'b0, vlist[i], 7, "R2");

        // R3: trim duty at nominal frequency down to the knee
        for (int k = 0; k < 8; k++) run_period(4, 1'b0, 37, -1, "R3");
        // R4: fold region stretches the period
        for (int k = 0; k < 16; k++) run_period(10, 1'b0, 37, 3, "R4");
        // R6: further excess at level zero cannot go below zero
        run_period(LEN, 1'b0, 37, -1, "R6");
        chk("R6", "per at floor level", int'(per_ticks), P_MAX);
        // R7: first clean period restores voltage mode in full
        run_period(0, 1'b0, 37, -1, "R7");
        run_period(1, 1'b0, 37, -1, "R7");
        // R7/R6: recover to the cap, then reveal the level
        for (int k = 0; k < 60; k++) run_period(0, 1'b0, 30, -1, "R7");
        run_period(1, 1'b0, 37, -1, "R6");
        // R5: upper trigger collapses at once
        run_period(1, 1'b1, 37, -1, "R5");
        run_period(1, 1'b1, 3, -1, "R5");
        run_period(0, 1'b0, 20, -1, "R7");
        run_period(2, 1'b1, 9, -1, "R5");
        // R9: small commands while folded
        for (int v = 0; v < 12; v++) run_period(1, 1'b0, v, -1, "R9");

        // Near-exhaustive sweep of excess counts, three periods deep each
        for (int lo = 1; lo <= LEN; lo++) begin
            for (int r = 0; r < 3; r++) run_period(lo, 1'b0, 37, -1, (m_lvl - lo >= KNEE) ? "R3" : "R4");
            while (m_lvl < LVL_MAX) run_period(0, 1'b0, 37, -1, "R7");
        end

        finish_run();
    end

endmodule